// File: doc/BRIEF.md
# Fractional DSP Multiply Unit

This unit is the multiply stage of a 32-bit processor datapath. Each operation takes two 32-bit source words, a bit per source that picks its upper or lower halfword, and a 4-bit operation code. One pass through a single signed multiplier array produces one of these: a plain low-word product, a signed halfword product, a signed word-by-halfword product up to 48 bits wide, a negated form of either of those, or a fractional (Q15/Q31) product with saturation and optional rounding.

Operands are captured on an input strobe. The result and a saturation pulse appear with an output strobe one clock later. Results narrower than 48 bits are zero-extended on the 64-bit result bus. The unit only reports that a fractional operation saturated. Keeping a sticky flag is left to the surrounding status logic.

Top module: `frac_mul_unit`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, the operands are captured and `out_valid` is high for exactly the following cycle. `out_valid` is low in every cycle that follows an edge where `in_valid` was low.
- R2: Op code 0 returns the low 32 bits of `src_a * src_b` in `result[31:0]`, with `result[63:32]` zero.
- R3: Op code 1 multiplies two signed halfwords and returns the 32-bit product. For each source, a select bit of 1 picks bits [31:16] and a select bit of 0 picks bits [15:0].
- R4: Op code 2 returns the two's complement of the op 1 product as 32 bits.
- R5: Op code 3 multiplies the whole signed `src_a` by the selected signed halfword of `src_b` and returns the 48-bit product in `result[47:0]`. `a_hi` has no effect.
- R6: Op code 4 returns the two's complement of the op 3 product as 48 bits.
- R7: Op code 5 (fractional, halfword out) doubles the signed halfword product and returns its bits [31:16] in `result[15:0]`.
- R8: Op code 6 (fractional, word out) returns the doubled signed halfword product as 32 bits.
- R9: Op code 7 (fractional word-by-halfword) doubles the op 3 product and returns its bits [47:16] in `result[31:0]`.
- R10: Op codes 8 and 9 are op 5 and op 7 with 0x8000 added to the doubled product before the field is taken.
- R11: A fractional op (5 to 9) whose two inputs both equal the most negative value returns 0x7FFF (ops 5 and 8) or 0x7FFFFFFF (ops 6, 7 and 9), and `sat` is high together with `out_valid`.
- R12: `sat` stays low for op codes 0 to 4, for fractional ops without saturation, and for unused op codes 10 to 15. Unused op codes also return a result of zero.
- R13: During reset, `out_valid`, `sat` and `result` are all zero.
- R14: While `in_valid` is low, changes on `src_a`, `src_b`, `a_hi`, `b_hi` and `op_code` leave `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand capture strobe |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| a_hi | input | 1 | Halfword select for `src_a` (1 = upper) |
| b_hi | input | 1 | Halfword select for `src_b` (1 = upper) |
| op_code | input | 4 | Operation code |
| out_valid | output | 1 | Result strobe, one cycle after capture |
| result | output | 64 | Zero-extended result |
| sat | output | 1 | Saturation pulse for the current result |

## Verification
Most faults in operand steering or halfword selection corrupt `result` in the very cycle `out_valid` rises. This holds for a wrong select bit, a missing sign extension, or a full word routed where a halfword belongs. A misplaced rounding carry or a wrong field offset shows up only for products with particular low-order bits. A sweep over edge values is therefore crossed with random operands. Clamping can fail in only one input pair per form. The sweep includes the most negative values, so a wrong clamp or a stray `sat` appears on the first transaction that hits that pair.

// File: rtl/fmu_pkg.sv
package fmu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_MUL           = 4'd0,
      OP_HH            = 4'd1,
      OP_HH_NEG        = 4'd2,
      OP_WH            = 4'd3,
      OP_WH_NEG        = 4'd4,
      OP_FRAC_HH_H     = 4'd5,
      OP_FRAC_HH_W     = 4'd6,
      OP_FRAC_WH_W     = 4'd7,
      OP_FRAC_HH_H_RND = 4'd8,
      OP_FRAC_WH_W_RND = 4'd9
   } fmu_op_e;

   // operations feeding the whole first source word into the array
   function automatic logic op_word_a(fmu_op_e op);
      return op inside {OP_MUL, OP_WH, OP_WH_NEG, OP_FRAC_WH_W, OP_FRAC_WH_W_RND};
   endfunction

   // operations allowed to raise the saturation pulse
   function automatic logic op_saturating(fmu_op_e op);
      return op inside {OP_FRAC_HH_H, OP_FRAC_HH_W, OP_FRAC_WH_W,
                        OP_FRAC_HH_H_RND, OP_FRAC_WH_W_RND};
   endfunction

   // saturating operations that return a halfword
   function automatic logic op_half_out(fmu_op_e op);
      return op inside {OP_FRAC_HH_H, OP_FRAC_HH_H_RND};
   endfunction

   // operations whose result may exceed one word
   function automatic logic op_wide_out(fmu_op_e op);
      return op inside {OP_WH, OP_WH_NEG};
   endfunction

endpackage

// File: rtl/fmu_half_pick.sv
module fmu_half_pick #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0]   word_i,
   input  logic                sel_hi_i,
   output logic [WORD_W/2-1:0] half_o
);
   localparam int HALF_W = WORD_W / 2;

   assign half_o = sel_hi_i ? word_i[WORD_W-1:HALF_W] : word_i[HALF_W-1:0];

endmodule

// File: rtl/fmu_mult_core.sv
module fmu_mult_core #(
   parameter int IN_W = 32,
   parameter int P_W  = 48
) (
   input  logic [IN_W-1:0] a_i,
   input  logic [IN_W-1:0] b_i,
   output logic [P_W-1:0]  p_o
);
   if (P_W < IN_W) begin : g_bad_pw
      $error("fmu_mult_core: P_W must be at least IN_W");
   end

   logic signed [P_W-1:0] a_ext;
   logic signed [P_W-1:0] b_ext;

   // sign-extend both operands to the product width; the truncated
   // product is exact for every operation this unit issues
   assign a_ext = {{(P_W-IN_W){a_i[IN_W-1]}}, a_i};
   assign b_ext = {{(P_W-IN_W){b_i[IN_W-1]}}, b_i};
   assign p_o   = a_ext * b_ext;

endmodule

// File: rtl/fmu_post.sv
module fmu_post
   import fmu_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int OUT_W  = 64
) (
   input  fmu_op_e                       op_i,
   input  logic [WORD_W+WORD_W/2-1:0]    prod_i,
   input  logic [WORD_W/2-1:0]           half_a_i,
   input  logic [WORD_W/2-1:0]           half_b_i,
   input  logic [WORD_W-1:0]             word_a_i,
   output logic [OUT_W-1:0]              res_o,
   output logic                          sat_o
);
   localparam int HALF_W = WORD_W / 2;
   localparam int PROD_W = WORD_W + HALF_W;
   localparam logic [HALF_W-1:0] H_MIN = {1'b1, {(HALF_W-1){1'b0}}};
   localparam logic [WORD_W-1:0] W_MIN = {1'b1, {(WORD_W-1){1'b0}}};
   localparam logic [HALF_W-1:0] H_MAX = {1'b0, {(HALF_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] W_MAX = {1'b0, {(WORD_W-1){1'b1}}};

   logic [WORD_W-1:0] p_hh;
   logic [PROD_W-1:0] p_wh;
   logic [HALF_W-1:0] hh_fld;
   logic [HALF_W-1:0] hh_fld_r;
   logic [WORD_W-1:0] wh_fld;
   logic [WORD_W-1:0] wh_fld_r;
   logic              min_hh;
   logic              min_wh;

   assign p_hh = prod_i[WORD_W-1:0];
   assign p_wh = prod_i;

   // kept field of the doubled product, read from the undoubled one
   assign hh_fld = p_hh[WORD_W-2:HALF_W-1];
   assign wh_fld = p_wh[PROD_W-2:HALF_W-1];

   // adding half an LSB of the kept field carries into it exactly when
   // the doubled product's bit just below the field is set
   assign hh_fld_r = hh_fld + {{(HALF_W-1){1'b0}}, p_hh[HALF_W-2]};
   assign wh_fld_r = wh_fld + {{(WORD_W-1){1'b0}}, p_wh[HALF_W-2]};

   // the only input pairs whose doubled product leaves the range
   assign min_hh = (half_a_i == H_MIN) && (half_b_i == H_MIN);
   assign min_wh = (word_a_i == W_MIN) && (half_b_i == H_MIN);

   always_comb begin
      res_o = '0;
      sat_o = 1'b0;
      unique case (op_i)
         OP_MUL:    res_o[WORD_W-1:0] = p_hh;
         OP_HH:     res_o[WORD_W-1:0] = p_hh;
         OP_HH_NEG: res_o[WORD_W-1:0] = -p_hh;
         OP_WH:     res_o[PROD_W-1:0] = p_wh;
         OP_WH_NEG: res_o[PROD_W-1:0] = -p_wh;
         OP_FRAC_HH_H: begin
            sat_o = min_hh;
            res_o[HALF_W-1:0] = min_hh ? H_MAX : hh_fld;
         end
         OP_FRAC_HH_W: begin
            sat_o = min_hh;
            res_o[WORD_W-1:0] = min_hh ? W_MAX : {p_hh[WORD_W-2:0], 1'b0};
         end
         OP_FRAC_WH_W: begin
            sat_o = min_wh;
            res_o[WORD_W-1:0] = min_wh ? W_MAX : wh_fld;
         end
         OP_FRAC_HH_H_RND: begin
            sat_o = min_hh;
            res_o[HALF_W-1:0] = min_hh ? H_MAX : hh_fld_r;
         end
         OP_FRAC_WH_W_RND: begin
            sat_o = min_wh;
            res_o[WORD_W-1:0] = min_wh ? W_MAX : wh_fld_r;
         end
         default: begin
            res_o = '0;
            sat_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/frac_mul_unit.sv
module frac_mul_unit
   import fmu_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int OUT_W  = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [WORD_W-1:0]    src_a,
   input  logic [WORD_W-1:0]    src_b,
   input  logic                 a_hi,
   input  logic                 b_hi,
   input  logic [OPC_W-1:0]     op_code,
   output logic                 out_valid,
   output logic [OUT_W-1:0]     result,
   output logic                 sat
);
   localparam int HALF_W = WORD_W / 2;
   localparam int PROD_W = WORD_W + HALF_W;
   localparam int N_SRC  = 2;
   localparam logic [OUT_W-1:0] CLAMP_H = OUT_W'({1'b0, {(HALF_W-1){1'b1}}});
   localparam logic [OUT_W-1:0] CLAMP_W = OUT_W'({1'b0, {(WORD_W-1){1'b1}}});

   if ((WORD_W < 8) || (WORD_W % 2 != 0)) begin : g_bad_word
      $error("frac_mul_unit: WORD_W must be even and at least 8");
   end
   if (OUT_W < PROD_W) begin : g_bad_out
      $error("frac_mul_unit: OUT_W must hold the word-by-halfword product");
   end

   // ---------------- operand capture ----------------
   logic [N_SRC-1:0][WORD_W-1:0] src_q;
   logic [N_SRC-1:0]             hi_q;
   logic [OPC_W-1:0]             op_q;
   logic                         vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= '0;
         hi_q  <= '0;
         op_q  <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            src_q[0] <= src_a;
            src_q[1] <= src_b;
            hi_q     <= {b_hi, a_hi};
            op_q     <= op_code;
         end
      end
   end

   fmu_op_e op_e;
   assign op_e = fmu_op_e'(op_q);

   // ---------------- halfword selection ----------------
   logic [N_SRC-1:0][HALF_W-1:0] half_s;

   for (genvar g = 0; g < N_SRC; g++) begin : g_pick
      fmu_half_pick #(.WORD_W(WORD_W)) u_pick (
         .word_i   (src_q[g]),
         .sel_hi_i (hi_q[g]),
         .half_o   (half_s[g])
      );
   end

   // ---------------- array operand steering ----------------
   logic [WORD_W-1:0] mul_a;
   logic [WORD_W-1:0] mul_b;

   always_comb begin
      mul_a = {{HALF_W{half_s[0][HALF_W-1]}}, half_s[0]};
      mul_b = {{HALF_W{half_s[1][HALF_W-1]}}, half_s[1]};
      if (op_word_a(op_e)) mul_a = src_q[0];
      if (op_e == OP_MUL)  mul_b = src_q[1];
   end

   logic [PROD_W-1:0] prod;

   fmu_mult_core #(.IN_W(WORD_W), .P_W(PROD_W)) u_mul (
      .a_i (mul_a),
      .b_i (mul_b),
      .p_o (prod)
   );

   // ---------------- result formatting ----------------
   logic post_sat;

   fmu_post #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_post (
      .op_i     (op_e),
      .prod_i   (prod),
      .half_a_i (half_s[0]),
      .half_b_i (half_s[1]),
      .word_a_i (src_q[0]),
      .res_o    (result),
      .sat_o    (post_sat)
   );

   assign out_valid = vld_q;
   assign sat       = vld_q & post_sat;

   // ---------------- assertions ----------------
   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   p_sat_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sat |-> op_saturating(op_e));

   p_sat_clamp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sat |-> (result == (op_half_out(op_e) ? CLAMP_H : CLAMP_W)));

   p_narrow_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !op_wide_out(op_e)) |-> (result[OUT_W-1:WORD_W] == '0));

endmodule

// File: tb/frac_mul_unit_tb_top.sv
module frac_mul_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;
   localparam int N_VALS     = 10;
   localparam logic [31:0] VALS [N_VALS] = '{
      32'h0000_0000, 32'h0000_0001, 32'h8000_8000, 32'h7FFF_7FFF, 32'hFFFF_FFFF,
      32'h8000_0000, 32'h0000_8000, 32'h1234_5678, 32'h7FFF_FFFF, 32'hFFFF_8000};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic        a_hi = 1'b0;
   logic        b_hi = 1'b0;
   logic [3:0]  op_code = '0;
   logic        out_valid;
   logic [63:0] result;
   logic        sat;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [63:0] last_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_mul_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
      .a_hi(a_hi), .b_hi(b_hi), .op_code(op_code),
      .out_valid(out_valid), .result(result), .sat(sat));

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(logic [3:0] op);
      case (op)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3: return "R5";
         4'd4: return "R6";
         4'd5: return "R7";
         4'd6: return "R8";
         4'd7: return "R9";
         4'd8, 4'd9: return "R10";
         default: return "R12";
      endcase
   endfunction

   // arithmetic model of every operation
   task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic ahi, input logic bhi,
                        output logic [63:0] r, output logic s);
      logic [15:0] hav, hbv;
      logic [63:0] t;
      longint ha, hb, sa, php, pwh;
      longint m32, m48;
      bit minhh, minwh;
      m32 = 64'h0000_0000_FFFF_FFFF;
      m48 = 64'h0000_FFFF_FFFF_FFFF;
      hav = ahi ? a[31:16] : a[15:0];
      hbv = bhi ? b[31:16] : b[15:0];
      ha  = longint'($signed(hav));
      hb  = longint'($signed(hbv));
      sa  = longint'($signed(a));
      php = ha * hb;
      pwh = sa * hb;
      minhh = (ha == -32768) && (hb == -32768);
      minwh = (sa == -64'sd2147483648) && (hb == -32768);
      s = 1'b0;
      r = '0;
      case (op)
         4'd0: begin t = {32'h0, a} * {32'h0, b}; r = {32'h0, t[31:0]}; end
         4'd1: r = php & m32;
         4'd2: r = (-php) & m32;
         4'd3: r = pwh & m48;
         4'd4: r = (-pwh) & m48;
         4'd5: if (minhh) begin r = 64'h7FFF; s = 1'b1; end
               else r = ((php * 2) >>> 16) & 64'hFFFF;
         4'd6: if (minhh) begin r = 64'h7FFF_FFFF; s = 1'b1; end
               else r = (php * 2) & m32;
         4'd7: if (minwh) begin r = 64'h7FFF_FFFF; s = 1'b1; end
               else r = ((pwh * 2) >>> 16) & m32;
         4'd8: if (minhh) begin r = 64'h7FFF; s = 1'b1; end
               else r = ((php * 2 + 32768) >>> 16) & 64'hFFFF;
         4'd9: if (minwh) begin r = 64'h7FFF_FFFF; s = 1'b1; end
               else r = ((pwh * 2 + 32768) >>> 16) & m32;
         default: begin r = '0; s = 1'b0; end
      endcase
   endtask

   task automatic do_op(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic ahi, logic bhi);
      logic [63:0] er;
      logic        es;
      model(op, a, b, ahi, bhi, er, es);
      @(negedge clk);
      op_code = op; src_a = a; src_b = b; a_hi = ahi; b_hi = bhi; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1", "out_valid after capture", {63'h0, out_valid}, 64'h1);
      check(tag_of(op), "result", result, er);
      check(es ? "R11" : "R12", "sat", {63'h0, sat}, {63'h0, es});
      last_exp = er;
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      // R13: reset state
      repeat (3) @(negedge clk);
      check("R13", "out_valid in reset", {63'h0, out_valid}, 64'h0);
      check("R13", "sat in reset", {63'h0, sat}, 64'h0);
      check("R13", "result in reset", result, 64'h0);
      rst_n = 1'b1;

      // sweep of edge values across all codes and halfword selects
      for (int op = 0; op < 16; op++) begin
         for (int sel = 0; sel < 4; sel++) begin
            for (int i = 0; i < N_VALS; i++) begin
               for (int j = 0; j < N_VALS; j++) begin
                  do_op(4'(op), VALS[i], VALS[j], sel[0], sel[1]);
               end
            end
         end
      end

      // random operands, with the most negative values mixed in
      for (int k = 0; k < 1500; k++) begin
         logic [31:0] ra, rb;
         ra = $urandom;
         rb = $urandom;
         if (k % 7 == 0) ra = 32'h8000_0000;
         if (k % 11 == 0) rb = 32'h8000_8000;
         do_op(4'($urandom_range(0, 15)), ra, rb, 1'($urandom), 1'($urandom));
      end

      // R14: inputs change without a strobe
      for (int k = 0; k < 40; k++) begin
         do_op(4'($urandom_range(0, 9)), $urandom, $urandom, 1'($urandom), 1'($urandom));
         src_a   = ~src_a;
         src_b   = src_b ^ 32'h8001_0001;
         a_hi    = ~a_hi;
         b_hi    = ~b_hi;
         op_code = op_code ^ 4'h1;
         @(negedge clk);
         check("R14", "result held", result, last_exp);
         check("R1", "out_valid idle", {63'h0, out_valid}, 64'h0);
         check("R12", "sat idle", {63'h0, sat}, 64'h0);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule